// File: doc/BRIEF.md
# Configuration Security Gate

This block controls access to a small on-chip configuration store. It holds a 64-bit user signature and a single one-way security bit, and it decides whether configuration read-back and register preload are allowed. Commands arrive one per cycle on a valid/opcode interface. Each accepted command produces a registered response one cycle later. The response carries either data or an access-denied indication.

Once the security bit is set, any later attempt to read configuration words or to preload registers is refused. The user signature stays readable and writable in every state. Only a full erase clears the security bit. The erase also wipes the whole configuration store, so protected content can never become readable again. The preload function drives a one-cycle strobe and value towards the registers it would force.

Top module: `cfg_sec_gate`

## Requirements
- R1: Opcode encoding on `cmd_op`: 0 idle, 1 read config, 2 read signature, 3 write signature, 4 preload, 5 secure, 6 erase, 7 program config. A command with `cmd_valid` high and a non-idle opcode raises `rsp_valid` for exactly one cycle, one clock after it is presented. An idle opcode, or `cmd_valid` low, produces no response.
- R2: Read signature returns the full 64-bit signature on `rsp_data` with `rsp_denied` low, whether or not the block is secured. Write signature takes `cmd_wdata` in every security state.
- R3: While unsecured, read config returns the word at `cmd_addr`, zero-extended to 64 bits. While secured, it is refused.
- R4: While unsecured, preload raises `pl_valid` for one cycle, one clock after the command, with `pl_data` equal to `cmd_wdata[PW-1:0]`. While secured, it is refused and `pl_valid` stays low.
- R5: A secure command sets `secured` at the next clock. Any read config or preload presented in the very next cycle is already refused.
- R6: The security bit is never cleared by any command other than erase.
- R7: Erase clears the security bit and sets every configuration word to zero. The signature keeps its value.
- R8: Program config writes `cmd_wdata[CW-1:0]` to the word at `cmd_addr` in every security state. Such a write is never refused.
- R9: A refused command raises `rsp_denied` for one cycle together with `rsp_valid`, and `rsp_data` is zero while `rsp_denied` is high.
- R10: After reset, `secured`, the signature, all configuration words and all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 3 | Command opcode |
| cmd_addr | input | AW | Configuration word address |
| cmd_wdata | input | 64 | Write data for signature, program and preload |
| rsp_valid | output | 1 | Response strobe, one cycle after the command |
| rsp_denied | output | 1 | Command was refused |
| rsp_data | output | 64 | Read data, zero on refusal and on writes |
| pl_valid | output | 1 | Preload strobe |
| pl_data | output | PW | Preload value |
| secured | output | 1 | Security bit state |

## Verification
The hardest case to reach is the boundary where a secure command is followed in the very next cycle by a read or a preload. The stimulus issues these back-to-back with no idle cycle between them. The second hard case is content written while secured: it must become unreadable for good. To cover it, the bench programs a word after securing, erases, and reads the word back. It then checks that the word reads as zero, not as the new content, while the signature survives the erase.

// File: rtl/cfg_sec_gate_pkg.sv
package cfg_sec_gate_pkg;

    typedef enum logic [2:0] {
        OP_IDLE    = 3'd0,
        OP_RD_CFG  = 3'd1,
        OP_RD_SIG  = 3'd2,
        OP_WR_SIG  = 3'd3,
        OP_PRELOAD = 3'd4,
        OP_SECURE  = 3'd5,
        OP_ERASE   = 3'd6,
        OP_PROG    = 3'd7
    } gate_op_e;

    localparam int unsigned SIG_W = 64;

endpackage

// File: rtl/cfg_sec_store.sv
module cfg_sec_store #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CW    = 32,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          clr_all,
    input  logic [AW-1:0] addr,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] rdata
);

    logic [CW-1:0] mem_d [DEPTH];
    logic [CW-1:0] mem_q [DEPTH];

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            if (clr_all) begin
                mem_d[i] = '0;
            end else if (wr_en && (int'(addr) == i)) begin
                mem_d[i] = wdata;
            end else begin
                mem_d[i] = mem_q[i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= mem_d[i];
        end
    end

    assign rdata = (int'(addr) < DEPTH) ? mem_q[addr] : '0;

endmodule

// File: rtl/cfg_sec_ctrl.sv
module cfg_sec_ctrl
    import cfg_sec_gate_pkg::*;
#(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CW    = 32,
    parameter int unsigned PW    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [2:0]       cmd_op,
    input  logic [SIG_W-1:0] cmd_wdata,
    input  logic [CW-1:0]    store_rdata,
    output logic             store_wr,
    output logic             store_clr,
    output logic             rsp_valid,
    output logic             rsp_denied,
    output logic [SIG_W-1:0] rsp_data,
    output logic             pl_valid,
    output logic [PW-1:0]    pl_data,
    output logic             secured
);

    typedef struct packed {
        logic             fuse;
        logic [SIG_W-1:0] sig;
        logic             rsp_valid;
        logic             rsp_denied;
        logic [SIG_W-1:0] rsp_data;
        logic             pl_valid;
        logic [PW-1:0]    pl_data;
    } ctrl_state_t;

    ctrl_state_t st_d, st_q;
    gate_op_e    op;

    assign op = gate_op_e'(cmd_op);

    always_comb begin
        st_d            = st_q;
        st_d.rsp_valid  = 1'b0;
        st_d.rsp_denied = 1'b0;
        st_d.rsp_data   = '0;
        st_d.pl_valid   = 1'b0;
        store_wr        = 1'b0;
        store_clr       = 1'b0;
        if (cmd_valid && op != OP_IDLE) begin
            st_d.rsp_valid = 1'b1;
            unique case (op)
                OP_RD_CFG: begin
                    if (st_q.fuse) st_d.rsp_denied = 1'b1;
                    else           st_d.rsp_data   = SIG_W'(store_rdata);
                end
                OP_RD_SIG: st_d.rsp_data = st_q.sig;
                OP_WR_SIG: st_d.sig      = cmd_wdata;
                OP_PRELOAD: begin
                    if (st_q.fuse) begin
                        st_d.rsp_denied = 1'b1;
                    end else begin
                        st_d.pl_valid = 1'b1;
                        st_d.pl_data  = cmd_wdata[PW-1:0];
                    end
                end
                OP_SECURE: st_d.fuse = 1'b1;
                OP_ERASE: begin
                    st_d.fuse = 1'b0;
                    store_clr = 1'b1;
                end
                OP_PROG:   store_wr = 1'b1;
                default:   st_d.rsp_valid = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rsp_valid  = st_q.rsp_valid;
    assign rsp_denied = st_q.rsp_denied;
    assign rsp_data   = st_q.rsp_data;
    assign pl_valid   = st_q.pl_valid;
    assign pl_data    = st_q.pl_data;
    assign secured    = st_q.fuse;

endmodule

// File: rtl/cfg_sec_gate.sv
module cfg_sec_gate #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned CW    = 32,
    parameter int unsigned PW    = 10,
    localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [AW-1:0] cmd_addr,
    input  logic [63:0]   cmd_wdata,
    output logic          rsp_valid,
    output logic          rsp_denied,
    output logic [63:0]   rsp_data,
    output logic          pl_valid,
    output logic [PW-1:0] pl_data,
    output logic          secured
);

    logic          store_wr;
    logic          store_clr;
    logic [CW-1:0] store_rdata;

    cfg_sec_store #(.DEPTH(DEPTH), .CW(CW)) i_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (store_wr),
        .clr_all (store_clr),
        .addr    (cmd_addr),
        .wdata   (cmd_wdata[CW-1:0]),
        .rdata   (store_rdata)
    );

    cfg_sec_ctrl #(.DEPTH(DEPTH), .CW(CW), .PW(PW)) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_wdata   (cmd_wdata),
        .store_rdata (store_rdata),
        .store_wr    (store_wr),
        .store_clr   (store_clr),
        .rsp_valid   (rsp_valid),
        .rsp_denied  (rsp_denied),
        .rsp_data    (rsp_data),
        .pl_valid    (pl_valid),
        .pl_data     (pl_data),
        .secured     (secured)
    );

endmodule

// File: rtl/cfg_sec_gate_chk.sv
module cfg_sec_gate_chk
    import cfg_sec_gate_pkg::*;
#(
    parameter int unsigned PW = 10
) (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic [2:0]  cmd_op,
    input logic        rsp_valid,
    input logic        rsp_denied,
    input logic [63:0] rsp_data,
    input logic        pl_valid,
    input logic        secured
);

    logic cmd_live;
    assign cmd_live = cmd_valid && (cmd_op != 3'(OP_IDLE));

    a_r1_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_live |=> rsp_valid);

    a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_live |=> !rsp_valid);

    a_r2_sig_never_denied: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'(OP_RD_SIG)) |=> !rsp_denied);

    a_r3_cfg_denied: assert property (@(posedge clk) disable iff (!rst_n)
        (secured && cmd_valid && cmd_op == 3'(OP_RD_CFG)) |=> rsp_denied);

    a_r4_preload_blocked: assert property (@(posedge clk) disable iff (!rst_n)
        (secured && cmd_valid && cmd_op == 3'(OP_PRELOAD)) |=> (rsp_denied && !pl_valid));

    a_r5_secure_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 3'(OP_SECURE)) |=> secured);

    a_r6_fuse_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (secured && !(cmd_valid && cmd_op == 3'(OP_ERASE))) |=> secured);

    a_r9_denied_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_denied |-> (rsp_valid && rsp_data == '0));

endmodule

bind cfg_sec_gate cfg_sec_gate_chk #(.PW(PW)) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .rsp_valid  (rsp_valid),
    .rsp_denied (rsp_denied),
    .rsp_data   (rsp_data),
    .pl_valid   (pl_valid),
    .secured    (secured)
);

// File: tb/test_cfg_sec_gate.sv
`timescale 1ns/1ps
module test_cfg_sec_gate;
    localparam int DEPTH = 16;
    localparam int CW    = 32;
    localparam int PW    = 10;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = '0;
    logic [AW-1:0] cmd_addr = '0;
    logic [63:0]   cmd_wdata = '0;
    logic          rsp_valid, rsp_denied, pl_valid, secured;
    logic [63:0]   rsp_data;
    logic [PW-1:0] pl_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    cfg_sec_gate #(.DEPTH(DEPTH), .CW(CW), .PW(PW)) i_cfg_sec_gate (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .rsp_valid(rsp_valid),
        .rsp_denied(rsp_denied), .rsp_data(rsp_data), .pl_valid(pl_valid),
        .pl_data(pl_data), .secured(secured)
    );

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive on negedge, response registered at next posedge, sample next negedge
    task automatic issue(input logic [2:0] op, input logic [AW-1:0] a, input logic [63:0] wd);
        cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = wd;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
    endtask

    task automatic t_reset;
        check("R10 secured", {63'd0, secured}, 64'd0);
        check("R10 rsp_valid", {63'd0, rsp_valid}, 64'd0);
        check("R10 pl_valid", {63'd0, pl_valid}, 64'd0);
        issue(3'd2, '0, '0);
        check("R10 sig zero", rsp_data, 64'd0);
        issue(3'd1, 4'd5, '0);
        check("R10 cfg zero", rsp_data, 64'd0);
    endtask

    task automatic t_idle;
        issue(3'd0, '0, 64'h1);
        check("R1 idle no rsp", {63'd0, rsp_valid}, 64'd0);
        issue(3'd2, '0, '0);
        check("R1 rsp valid", {63'd0, rsp_valid}, 64'd1);
        @(negedge clk);
        check("R1 one cycle", {63'd0, rsp_valid}, 64'd0);
    endtask

    task automatic t_open_access;
        issue(3'd3, '0, 64'hDEAD_BEEF_0123_4567);
        issue(3'd2, '0, '0);
        check("R2 sig read", rsp_data, 64'hDEAD_BEEF_0123_4567);
        issue(3'd7, 4'd3, 64'hFFFF_FFFF_A5A5_5A5A);
        issue(3'd7, 4'd15, 64'h0000_0000_1234_5678);
        issue(3'd1, 4'd3, '0);
        check("R3 cfg read", rsp_data, 64'h0000_0000_A5A5_5A5A);
        check("R3 not denied", {63'd0, rsp_denied}, 64'd0);
        issue(3'd1, 4'd15, '0);
        check("R3 cfg read top", rsp_data, 64'h1234_5678);
        issue(3'd4, '0, 64'h3FF_F2AB);
        check("R4 pl_valid", {63'd0, pl_valid}, 64'd1);
        check("R4 pl_data", {54'd0, pl_data}, 64'h2AB);
        @(negedge clk);
        check("R4 pl one cycle", {63'd0, pl_valid}, 64'd0);
    endtask

    task automatic t_secure;
        cmd_valid = 1'b1; cmd_op = 3'd5; cmd_addr = '0; cmd_wdata = '0;
        @(negedge clk);
        check("R5 secured", {63'd0, secured}, 64'd1);
        cmd_op = 3'd1; cmd_addr = 4'd3;   // back-to-back read
        @(negedge clk);
        check("R5 R3 denied next cycle", {63'd0, rsp_denied}, 64'd1);
        check("R9 denied data zero", rsp_data, 64'd0);
        cmd_op = 3'd4; cmd_wdata = 64'h155;
        @(negedge clk);
        cmd_valid = 1'b0; cmd_op = 3'd0;
        check("R4 preload denied", {63'd0, rsp_denied}, 64'd1);
        check("R4 no pl_valid", {63'd0, pl_valid}, 64'd0);
        check("R4 pl_data held", {54'd0, pl_data}, 64'h2AB);
        @(negedge clk);
        check("R9 denied one cycle", {63'd0, rsp_denied}, 64'd0);
        issue(3'd2, '0, '0);
        check("R2 sig read secured", rsp_data, 64'hDEAD_BEEF_0123_4567);
        issue(3'd3, '0, 64'h0F0F_0000_FFFF_1111);
        check("R2 sig write not denied", {63'd0, rsp_denied}, 64'd0);
        issue(3'd2, '0, '0);
        check("R2 sig new secured", rsp_data, 64'h0F0F_0000_FFFF_1111);
        issue(3'd7, 4'd9, 64'h7777_7777);
        check("R8 prog not denied", {63'd0, rsp_denied}, 64'd0);
        issue(3'd5, '0, '0);
        issue(3'd4, '0, '0);
        check("R6 still secured", {63'd0, secured}, 64'd1);
    endtask

    task automatic t_erase;
        issue(3'd6, '0, '0);
        check("R7 fuse cleared", {63'd0, secured}, 64'd0);
        issue(3'd1, 4'd3, '0);
        check("R7 cfg cleared", rsp_data, 64'd0);
        issue(3'd1, 4'd9, '0);
        check("R7 R8 secured write wiped", rsp_data, 64'd0);
        issue(3'd2, '0, '0);
        check("R7 sig kept", rsp_data, 64'h0F0F_0000_FFFF_1111);
        issue(3'd7, 4'd9, 64'hCAFE);
        issue(3'd1, 4'd9, '0);
        check("R8 prog after erase", rsp_data, 64'hCAFE);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_idle();
        t_open_access();
        t_secure();
        t_erase();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end
endmodule